// File: doc/BRIEF.md
# Queue Error Interrupt Controller with Automatic Queue Halt

This block collects the miscellaneous error and notification events of one instruction queue into five sticky cause bits. It qualifies them with a per-bit enable mask and drives one level interrupt line. Software reaches the causes, the enables and the queue-run bit through a small register port.

Each cause has three ways to change. A hardware pulse sets it. A write-one-to-clear view clears it. A write-one-to-set view forces it, which lets software test the interrupt path.

Three of the causes count as queue-halting faults: the result-write response error, the instruction-read response error and the doorbell overflow. When any of them is set, by hardware or by software, the queue-run bit drops on the same clock edge. A continue-on-error input disables this halting for diagnostic runs.

Top module: `qerr_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all cause bits, all enable bits, the queue-run bit and `irq` are 0.
- R2: A one-cycle pulse on `hw_evt[i]` sets cause bit i, and the bit stays set until software clears it. The cause bits are: bit 4 engine software error, bit 3 result-write response error, bit 2 instruction-read response error, bit 1 doorbell overflow, bit 0 mailbox (its pulse marks a mailbox register write). A read at address 0 returns the cause bits in these positions.
- R3: A write to address 0 clears exactly the cause bits written as 1 and leaves the others unchanged. If a hardware pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to address 1 sets exactly the cause bits written as 1. A read at address 1 returns the cause bits.
- R5: A write to address 2 sets the enable bits written as 1, and a write to address 3 clears the enable bits written as 1. Bits written as 0 are unchanged. Reads at address 2 and at address 3 both return the enable bits.
- R6: `irq` is 1 exactly when some cause bit and its enable bit are both 1. It reflects the register state updated at the most recent clock edge.
- R7: A write to address 4 loads bit 0 of the write data into the queue-run bit. That bit drives `q_enable` and reads back at address 4, bit 0. Reads at any other address return 0.
- R8: When `cont_on_err` is 0, setting cause bit 3, 2 or 1 clears the queue-run bit on that edge, whether the set comes from hardware or from address 1. This takes priority over a write of 1 to address 4 in the same cycle.
- R9: Setting cause bit 4 or bit 0 never changes the queue-run bit.
- R10: When `cont_on_err` is 1, no cause set changes the queue-run bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt | input | 5 | Hardware event pulses, one per cause bit |
| cont_on_err | input | 1 | 1 = faults do not halt the queue |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 5 | Register write data |
| rdata | output | 5 | Register read data (combinational on `addr`) |
| irq | output | 1 | Interrupt line |
| q_enable | output | 1 | Queue-run state |

## Verification
All 32 hardware event patterns are driven with `cont_on_err` both low and high. This separates the halting subset from the benign causes and shows that a set cause also drives `irq`. The same 32 patterns are then applied through the software set view, which shows that software sets halt the queue just as hardware sets do. Sweeps over every clear mask and every enable mask confirm the bit-exact clearing and the gating of `irq`. Directed same-cycle collisions test the two priority rules: a set beats a clear, and a halt beats a run write.

// File: rtl/qerr_pkg.sv
package qerr_pkg;

    localparam int N_CAUSE = 5;
    localparam int ADDR_W  = 3;

    // Cause bit positions (software decodes these)
    localparam int C_SWERR = 4;
    localparam int C_RESWR = 3;
    localparam int C_INSRD = 2;
    localparam int C_DBOVF = 1;
    localparam int C_MBOX  = 0;

    localparam logic [N_CAUSE-1:0] HALT_MASK_DFLT =
        N_CAUSE'((1 << C_RESWR) | (1 << C_INSRD) | (1 << C_DBOVF));

    typedef enum logic [ADDR_W-1:0] {
        A_CAUSE_W1C = 3'd0,
        A_CAUSE_W1S = 3'd1,
        A_ENA_W1S   = 3'd2,
        A_ENA_W1C   = 3'd3,
        A_QRUN      = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic cause_clr;
        logic cause_set;
        logic ena_set;
        logic ena_clr;
        logic qrun;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic we, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d.cause_clr = we && (a == A_CAUSE_W1C);
        d.cause_set = we && (a == A_CAUSE_W1S);
        d.ena_set   = we && (a == A_ENA_W1S);
        d.ena_clr   = we && (a == A_ENA_W1C);
        d.qrun      = we && (a == A_QRUN);
        return d;
    endfunction

endpackage

// File: rtl/qerr_cause_bank.sv
module qerr_cause_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] cause
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                       cause[i] <= 1'b0;
            else if (hw_set[i] | sw_set[i]) cause[i] <= 1'b1;
            else if (sw_clr[i])            cause[i] <= 1'b0;
        end

        // R3: a set in the same cycle as a clear leaves the bit set
        assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && (hw_set[i] || sw_set[i])) |-> cause[i]);

        // R2: a set bit stays set unless a clear was written
        assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && cause[i] && !sw_clr[i]) |-> cause[i]);
    end

endmodule

// File: rtl/qerr_enable_reg.sv
module qerr_enable_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] ena
);

    always_ff @(posedge clk) begin
        if (rst) ena <= '0;
        else     ena <= (ena & ~clr_mask) | set_mask;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_ena_set_R5: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && set_mask[i]) |-> ena[i]);
        assert_ena_clr_R5: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && clr_mask[i] && !set_mask[i]) |-> !ena[i]);
    end

endmodule

// File: rtl/qerr_queue_ctl.sv
module qerr_queue_ctl #(
    parameter int         N         = 5,
    parameter logic [N-1:0] HALT_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic         cont_on_err,
    input  logic         run_wr,
    input  logic         run_wdata,
    output logic         q_run
);

    logic halt_req;
    assign halt_req = !cont_on_err && |(set_evt & HALT_MASK);

    always_ff @(posedge clk) begin
        if (rst)          q_run <= 1'b0;
        else if (halt_req) q_run <= 1'b0;
        else if (run_wr)   q_run <= run_wdata;
    end

    assert_fault_halts_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !cont_on_err && ((set_evt & HALT_MASK) != '0)) |-> !q_run);

    assert_benign_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && q_run && !run_wr && ((set_evt & HALT_MASK) == '0)) |-> q_run);

    assert_continue_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && q_run && cont_on_err && !run_wr) |-> q_run);

endmodule

// File: rtl/qerr_irq_ctrl.sv
module qerr_irq_ctrl
    import qerr_pkg::*;
#(
    parameter int               NC        = N_CAUSE,
    parameter logic [NC-1:0]    HALT_MASK = HALT_MASK_DFLT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NC-1:0]     hw_evt,
    input  logic              cont_on_err,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NC-1:0]     wdata,
    output logic [NC-1:0]     rdata,
    output logic              irq,
    output logic              q_enable
);

    wr_dec_t       dec;
    logic [NC-1:0] sw_set, sw_clr, ena_set, ena_clr;
    logic [NC-1:0] cause, ena;

    assign dec     = decode_wr(wr_en, addr);
    assign sw_set  = dec.cause_set ? wdata : '0;
    assign sw_clr  = dec.cause_clr ? wdata : '0;
    assign ena_set = dec.ena_set   ? wdata : '0;
    assign ena_clr = dec.ena_clr   ? wdata : '0;

    qerr_cause_bank #(.N(NC)) u_cause (
        .clk    (clk),
        .rst    (rst),
        .hw_set (hw_evt),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .cause  (cause)
    );

    qerr_enable_reg #(.N(NC)) u_ena (
        .clk      (clk),
        .rst      (rst),
        .set_mask (ena_set),
        .clr_mask (ena_clr),
        .ena      (ena)
    );

    qerr_queue_ctl #(.N(NC), .HALT_MASK(HALT_MASK)) u_qctl (
        .clk         (clk),
        .rst         (rst),
        .set_evt     (hw_evt | sw_set),
        .cont_on_err (cont_on_err),
        .run_wr      (dec.qrun),
        .run_wdata   (wdata[0]),
        .q_run       (q_enable)
    );

    assign irq = |(cause & ena);

    always_comb begin
        case (addr)
            A_CAUSE_W1C, A_CAUSE_W1S: rdata = cause;
            A_ENA_W1S,   A_ENA_W1C:   rdata = ena;
            A_QRUN:                   rdata = NC'(q_enable);
            default:                  rdata = '0;
        endcase
    end

    // R1: nothing is pending in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && !q_enable));

    // R6: with all enables cleared the line stays low
    assert_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (ena == '0) |-> !irq);

endmodule

// File: tb/qerr_irq_ctrl_tb.sv
module qerr_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] hw_evt;
    logic       cont_on_err;
    logic       wr_en;
    logic [2:0] addr;
    logic [4:0] wdata;
    logic [4:0] rdata;
    logic       irq;
    logic       q_enable;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qerr_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .hw_evt(hw_evt), .cont_on_err(cont_on_err),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .q_enable(q_enable)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus; returns just after the following negedge
    task automatic step(input logic [4:0] evt, input logic we,
                        input logic [2:0] a, input logic [4:0] d);
        @(negedge clk);
        hw_evt = evt; wr_en = we; addr = a; wdata = d;
        @(negedge clk);
        hw_evt = '0; wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [4:0] v);
        addr = a; wr_en = 1'b0;
        #1 v = rdata;
    endtask

    // Clean slate: no causes, no enables, queue stopped
    task automatic scrub();
        step(5'd0, 1'b1, 3'd0, 5'h1f);
        step(5'd0, 1'b1, 3'd3, 5'h1f);
        step(5'd0, 1'b1, 3'd4, 5'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [4:0] v;
        rst = 1'b1; hw_evt = '0; cont_on_err = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 q_enable", q_enable, 0);
        rd(3'd0, v); chk("R1 cause", v, 0);
        rd(3'd2, v); chk("R1 enable", v, 0);
        rd(3'd4, v); chk("R1 qrun", v, 0);

        // R7 run bit load and readback, other addresses read 0
        step(5'd0, 1'b1, 3'd4, 5'd1);
        chk("R7 q_enable set", q_enable, 1);
        rd(3'd4, v); chk("R7 qrun read", v, 1);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); chk("R7 unmapped read", v, 0);
        end
        step(5'd0, 1'b1, 3'd4, 5'd0);
        chk("R7 q_enable clear", q_enable, 0);

        // R2 R8 R9 R10 R6: hardware pulse sweep, both continue settings
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 32; p++) begin
                scrub();
                cont_on_err = c[0];
                step(5'd0, 1'b1, 3'd2, 5'h1f);
                step(5'd0, 1'b1, 3'd4, 5'd1);
                step(5'(p), 1'b0, 3'd0, 5'd0);
                rd(3'd0, v); chk("R2 hw cause", v, p);
                chk("R6 irq hw", irq, (p != 0) ? 1 : 0);
                chk(c ? "R10 q_enable hw" : "R8 R9 q_enable hw", q_enable,
                    (c == 1 || (p & 5'b01110) == 0) ? 1 : 0);
                // stickiness: idle cycles keep it
                step(5'd0, 1'b0, 3'd0, 5'd0);
                rd(3'd0, v); chk("R2 sticky", v, p);
            end
        end

        // R4 R8 R10: software set sweep
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 32; p++) begin
                scrub();
                cont_on_err = c[0];
                step(5'd0, 1'b1, 3'd4, 5'd1);
                step(5'd0, 1'b1, 3'd1, 5'(p));
                rd(3'd1, v); chk("R4 sw set cause", v, p);
                chk(c ? "R10 q_enable sw" : "R8 q_enable sw", q_enable,
                    (c == 1 || (p & 5'b01110) == 0) ? 1 : 0);
            end
        end
        cont_on_err = 1'b0;

        // R3 clear mask sweep
        for (int p = 0; p < 32; p++) begin
            step(5'd0, 1'b1, 3'd1, 5'h1f);
            step(5'd0, 1'b1, 3'd0, 5'(p));
            rd(3'd0, v); chk("R3 w1c", v, 31 & ~p);
        end

        // R5 R6 enable mask sweep with all causes set
        for (int m = 0; m < 32; m++) begin
            step(5'd0, 1'b1, 3'd1, 5'h1f);
            step(5'd0, 1'b1, 3'd3, 5'h1f);
            step(5'd0, 1'b1, 3'd2, 5'(m));
            rd(3'd2, v); chk("R5 ena read w1s view", v, m);
            rd(3'd3, v); chk("R5 ena read w1c view", v, m);
            chk("R6 irq mask", irq, (m != 0) ? 1 : 0);
        end
        // R5 w1c clears only written ones
        step(5'd0, 1'b1, 3'd2, 5'h1f);
        step(5'd0, 1'b1, 3'd3, 5'b00101);
        rd(3'd2, v); chk("R5 partial clear", v, 5'b11010);

        // R6 per-bit gating: single cause, all other enables
        for (int b = 0; b < 5; b++) begin
            scrub();
            step(5'd0, 1'b1, 3'd2, 5'h1f & ~(5'd1 << b));
            step(5'd0, 1'b1, 3'd1, 5'd1 << b);
            chk("R6 irq off-bit", irq, 0);
            step(5'd0, 1'b1, 3'd2, 5'd1 << b);
            chk("R6 irq on-bit", irq, 1);
        end

        // R3 set wins over same-cycle clear
        scrub();
        step(5'b10000, 1'b0, 3'd0, 5'd0);
        step(5'b10000, 1'b1, 3'd0, 5'b10000);
        rd(3'd0, v); chk("R3 set wins", v, 5'b10000);

        // R8 halt beats same-cycle run write of 1
        scrub();
        step(5'b00010, 1'b1, 3'd4, 5'd1);
        chk("R8 halt over run write", q_enable, 0);
        // R8 re-enable allowed while cause still pending, then halt again on new fault
        step(5'd0, 1'b1, 3'd4, 5'd1);
        chk("R8 reenable", q_enable, 1);
        step(5'b01000, 1'b0, 3'd0, 5'd0);
        chk("R8 second fault", q_enable, 0);

        // R1 reset clears everything again
        step(5'd0, 1'b1, 3'd1, 5'h1f);
        step(5'd0, 1'b1, 3'd2, 5'h1f);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 irq after reset", irq, 0);
        rd(3'd0, v); chk("R1 cause after reset", v, 0);
        rd(3'd3, v); chk("R1 enable after reset", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule